// File: doc/BRIEF.md
# Static LCD Segment Driver

This block drives a static (one backplane) liquid-crystal panel showing three full seven-segment digits, a leading half digit that can only show "1", a minus sign and a set of decimal points. It divides the system oscillator clock by `DIV` to make a square-wave backplane. Every segment line is the backplane XORed with that segment's on/off state. A lit segment is therefore driven in antiphase to the backplane, and a dark segment is driven in phase with it. In normal operation no segment ever sees a DC voltage.

The reading comes from the converter as packed BCD digits, an overflow-to-thousand flag, a negative flag and per-point decimal selects. The block captures these only on a load strobe, so the panel never shows a count that is still changing. A lamp-test request overrides everything and lights the whole panel as "-1888". In that mode the segment lines are held constant instead of toggling, so the request should only be held for a short time.

Top module: `lcd_static_drv`

## Requirements
- R1: `bp` is a 50 % duty square wave. It changes level once every `DIV/2` clock cycles, so one full period is `DIV` clocks.
- R2: While the synchronous reset `rst` is high at a clock edge, the divider clears and `bp` goes to 0. The captured reading also clears to digits 0, no thousand, not negative and all decimal points off.
- R3: Outside lamp test, a segment that is off drives the same level as `bp`.
- R4: Outside lamp test, a segment that is on drives the inverse of `bp`, so it toggles whenever `bp` toggles.
- R5: Digit i occupies `seg_digit[7*i+6:7*i]`, with bit 0 = a through bit 6 = g. BCD 0..9 light these segment masks: 0=7'h3F, 1=7'h06, 2=7'h5B, 3=7'h4F, 4=7'h66, 5=7'h6D, 6=7'h7D, 7=7'h07, 8=7'h7F, 9=7'h6F. Digit 0 sits in `digit_bcd[3:0]`.
- R6: BCD codes 10 to 15 light no segment of that digit.
- R7: Both half-digit lines (segments b and c of the leading "1") are on exactly when the captured thousand flag is 1. The minus line is on exactly when the captured negative flag is 1.
- R8: Decimal point j is on exactly when the captured bit j of `dp_sel` is 1.
- R9: The digit, thousand, negative and point inputs are captured at a clock edge where `load` is 1 and appear on the outputs from that edge on. With `load` at 0, changes on those inputs have no effect on any output.
- R10: While `lamp_test` is 1, every segment, half-digit, minus and decimal-point line is held at a constant 1, showing "-1888" with all points lit. `bp` keeps toggling. Once the request is released, the captured reading is shown again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Capture strobe for the reading inputs |
| digit_bcd | input | 4*DIGITS | Packed BCD digits, digit 0 lowest |
| thousand | input | 1 | Reading is 1000 or more |
| negative | input | 1 | Reading is negative |
| dp_sel | input | DP_N | Decimal point selects |
| lamp_test | input | 1 | Light-all override |
| bp | output | 1 | Backplane square wave |
| seg_digit | output | 7*DIGITS | Segment lines a..g per digit |
| seg_half | output | 2 | Leading "1" segment lines (b, c) |
| seg_minus | output | 1 | Minus sign line |
| seg_dp | output | DP_N | Decimal point lines |

## Verification
The bench builds the driver with `DIV=8`, three digits and three points. The backplane then toggles every four clocks. Within a short run, each captured reading is therefore seen in both backplane phases, and a lamp-test window spans several toggles, so constant lines can be told apart from antiphase ones. With this divider the bench also checks the toggle spacing from reset, and it exercises the non-decimal codes and reloads with no strobe between backplane edges.

// File: rtl/lcd_static_drv.sv
module lcd_static_drv #(
  parameter int DIV    = 800,
  parameter int DIGITS = 3,
  parameter int DP_N   = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [4*DIGITS-1:0]   digit_bcd,
  input  logic                  thousand,
  input  logic                  negative,
  input  logic [DP_N-1:0]       dp_sel,
  input  logic                  lamp_test,
  output logic                  bp,
  output logic [7*DIGITS-1:0]   seg_digit,
  output logic [1:0]            seg_half,
  output logic                  seg_minus,
  output logic [DP_N-1:0]       seg_dp
);

  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0]         cnt;
  logic                  bp_r;
  logic [4*DIGITS-1:0]   q_bcd;
  logic                  q_thou, q_neg;
  logic [DP_N-1:0]       q_dp;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      bp_r <= 1'b0;
    end else if (cnt == CW'(HALF - 1)) begin
      cnt  <= '0;
      bp_r <= ~bp_r;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_bcd  <= '0;
      q_thou <= 1'b0;
      q_neg  <= 1'b0;
      q_dp   <= '0;
    end else if (load) begin
      q_bcd  <= digit_bcd;
      q_thou <= thousand;
      q_neg  <= negative;
      q_dp   <= dp_sel;
    end
  end

  function automatic logic [6:0] seg7(input logic [3:0] d);
    case (d)
      4'd0:    seg7 = 7'h3F;
      4'd1:    seg7 = 7'h06;
      4'd2:    seg7 = 7'h5B;
      4'd3:    seg7 = 7'h4F;
      4'd4:    seg7 = 7'h66;
      4'd5:    seg7 = 7'h6D;
      4'd6:    seg7 = 7'h7D;
      4'd7:    seg7 = 7'h07;
      4'd8:    seg7 = 7'h7F;
      4'd9:    seg7 = 7'h6F;
      default: seg7 = 7'h00;
    endcase
  endfunction

  genvar i;
  generate
    for (i = 0; i < DIGITS; i++) begin : g_dig
      assign seg_digit[7*i +: 7] = lamp_test ? 7'h7F
                                 : ({7{bp_r}} ^ seg7(q_bcd[4*i +: 4]));
    end
  endgenerate

  assign bp        = bp_r;
  assign seg_half  = lamp_test ? 2'b11 : {2{bp_r ^ q_thou}};
  assign seg_minus = lamp_test | (bp_r ^ q_neg);
  assign seg_dp    = lamp_test ? {DP_N{1'b1}} : ({DP_N{bp_r}} ^ q_dp);

endmodule

// File: rtl/lcd_static_drv_chk.sv
module lcd_static_drv_chk #(
  parameter int DIV    = 800,
  parameter int DIGITS = 3,
  parameter int DP_N   = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  load,
  input logic [4*DIGITS-1:0]   digit_bcd,
  input logic                  thousand,
  input logic                  negative,
  input logic [DP_N-1:0]       dp_sel,
  input logic                  lamp_test,
  input logic                  bp,
  input logic [7*DIGITS-1:0]   seg_digit,
  input logic [1:0]            seg_half,
  input logic                  seg_minus,
  input logic [DP_N-1:0]       seg_dp
);

  localparam int HALF = DIV / 2;
  localparam int RW   = $clog2(DIV + 2);

  logic          bp_q;
  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      bp_q <= 1'b0;
      run  <= '0;
    end else begin
      bp_q <= bp;
      run  <= (bp != bp_q) ? '0 : run + 1'b1;
    end
  end

  // R2
  rst_bp_low_chk: assert property (@(posedge clk) rst |=> !bp);

  // R1
  bp_period_chk: assert property (@(posedge clk) disable iff (rst)
    run <= RW'(HALF));

  // R10
  lamp_all_on_chk: assert property (@(posedge clk) disable iff (rst)
    lamp_test |-> (&seg_digit && &seg_half && seg_minus && &seg_dp));

  // R4
  no_dc_chk: assert property (@(posedge clk) disable iff (rst)
    (!lamp_test && !$past(lamp_test) && !$past(load) && !$past(rst) && bp != $past(bp))
      |-> (seg_digit == ~$past(seg_digit) && seg_dp == ~$past(seg_dp)
           && seg_minus == ~$past(seg_minus)));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!lamp_test && !$past(lamp_test) && !$past(load) && !$past(rst) && bp == $past(bp))
      |-> ($stable(seg_digit) && $stable(seg_half) && $stable(seg_dp)));

endmodule

bind lcd_static_drv lcd_static_drv_chk #(.DIV(DIV), .DIGITS(DIGITS), .DP_N(DP_N)) u_chk (.*);

// File: tb/tb_lcd_static_drv.sv
module tb_lcd_static_drv;
  localparam int DIV = 8, DIGITS = 3, DP_N = 3, HALF = DIV / 2;

  logic clk = 0, rst = 1, load = 0, thousand = 0, negative = 0, lamp_test = 0;
  logic [4*DIGITS-1:0] digit_bcd = '0;
  logic [DP_N-1:0] dp_sel = '0;
  logic bp, seg_minus;
  logic [7*DIGITS-1:0] seg_digit;
  logic [1:0] seg_half;
  logic [DP_N-1:0] seg_dp;

  int checks = 0, fails = 0;

  logic [4*DIGITS-1:0] m_bcd = '0;
  logic m_thou = 0, m_neg = 0;
  logic [DP_N-1:0] m_dp = '0;

  lcd_static_drv #(.DIV(DIV), .DIGITS(DIGITS), .DP_N(DP_N)) dut (.*);

  always #10 clk = ~clk;

  function automatic logic [6:0] exp7(input logic [3:0] d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req);
    logic [7*DIGITS-1:0] e;
    for (int i = 0; i < DIGITS; i++) e[7*i +: 7] = {7{bp}} ^ exp7(m_bcd[4*i +: 4]);
    chk(seg_digit === e, req, 64'(seg_digit), 64'(e));
    chk(seg_half === {2{bp ^ m_thou}} && seg_minus === (bp ^ m_neg), {req, "/R7"},
        {61'd0, seg_half, seg_minus}, {61'd0, {2{bp ^ m_thou}}, bp ^ m_neg});
    chk(seg_dp === ({DP_N{bp}} ^ m_dp), {req, "/R8"}, 64'(seg_dp), 64'({DP_N{bp}} ^ m_dp));
  endtask

  task automatic do_load(input logic [4*DIGITS-1:0] b, input logic t, input logic n, input logic [DP_N-1:0] d);
    digit_bcd = b; thousand = t; negative = n; dp_sel = d; load = 1;
    @(negedge clk);
    load = 0;
    m_bcd = b; m_thou = t; m_neg = n; m_dp = d;
  endtask

  function automatic logic [4*DIGITS-1:0] rnd_bcd(input bit allow_hex);
    logic [4*DIGITS-1:0] r;
    for (int i = 0; i < DIGITS; i++)
      r[4*i +: 4] = allow_hex ? 4'($urandom_range(0, 15)) : 4'($urandom_range(0, 9));
    return r;
  endfunction

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R2 reset state
    chk(bp === 1'b0, "R2", 64'(bp), 0);
    chk_out("R2");
    rst = 0;

    // R1 toggle spacing from reset release
    begin
      int last = 0, k = 0;
      logic prev = 0;
      for (int c = 1; c <= 6 * HALF; c++) begin
        @(negedge clk);
        if (bp !== prev) begin
          chk(c - last == HALF, "R1", 64'(c - last), 64'(HALF));
          last = c; prev = bp; k++;
        end
      end
      chk(k == 6, "R1", 64'(k), 6);
    end

    // R5 R3 R4 directed
    for (int v = 0; v < 10; v++) begin
      do_load({DIGITS{4'(v)}}, v[0], v[1], DP_N'(v));
      chk_out("R5");
      @(negedge clk); chk_out("R4");
    end
    // R6 non-decimal codes blank
    do_load({4'd15, 4'd12, 4'd10}, 0, 0, '0);
    for (int c = 0; c < HALF + 1; c++) begin chk_out("R6"); @(negedge clk); end

    // R9 random with ignored bus changes
    for (int it = 0; it < 60; it++) begin
      do_load(rnd_bcd(it % 5 == 0), 1'($urandom), 1'($urandom), DP_N'($urandom));
      chk_out("R3");
      for (int c = 0; c < 3; c++) begin
        digit_bcd = rnd_bcd(1); thousand = 1'($urandom); negative = 1'($urandom);
        dp_sel = DP_N'($urandom);
        @(negedge clk);
        chk_out("R9");
      end
    end

    // R10 lamp test
    lamp_test = 1;
    begin
      int tog = 0;
      logic pb = bp;
      for (int c = 0; c < 3 * HALF; c++) begin
        @(negedge clk);
        if (bp !== pb) tog++;
        pb = bp;
        chk(&seg_digit && &seg_half && seg_minus && &seg_dp, "R10",
            {seg_digit, seg_half, seg_minus, seg_dp}, {(7*DIGITS+3+DP_N){1'b1}});
      end
      chk(tog >= 2, "R10", 64'(tog), 2);
    end
    lamp_test = 0;
    #1;
    chk_out("R10");
    @(negedge clk); chk_out("R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule